// File: doc/BRIEF.md
# Persistence-Filtered Overhead Byte Monitor

This block watches one 8-bit overhead byte that has already been extracted from each received frame and is presented with a one-cycle frame strobe. It accepts a new value only when that value has appeared unchanged for a programmable number of consecutive frames. When it accepts a value, it keeps both the accepted value and the value that value replaced.

Each accepted change sets a sticky delta flag. A mask bit gates the delta flag onto a registered interrupt output. A configuration input selects how the flag is cleared. In one mode a write strobe carrying a 1 clears it. In the other mode a read strobe clears it.

Top module: `ovh_byte_monitor`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `cur_byte`, `prev_byte`, `delta` and `irq` are all 0.
- R2: When `frame_byte` holds the same value V for N consecutive strobed frames and V differs from `cur_byte`, `cur_byte` becomes V on the clock edge that ends the Nth strobed frame, where N is `persist_n`. Before that edge it keeps its old value.
- R3: A strobed frame whose byte differs from the running candidate makes that byte the new candidate with a run length of one. Earlier matching frames then no longer count.
- R4: On every acceptance, `prev_byte` takes the value that `cur_byte` held just before the acceptance.
- R5: A value equal to `cur_byte` never changes `cur_byte` or `prev_byte` and never sets `delta`, however long it persists.
- R6: A `persist_n` of 0 behaves like 1, so a single strobed frame is enough to accept a differing value.
- R7: `delta` rises on the edge that performs an acceptance. It then stays high until a clear event.
- R8: With `clr_mode` = 0 (clear on write), a cycle with `wr_strobe` = 1 and `wr_bit` = 1 clears `delta`. `rd_strobe`, and a write with `wr_bit` = 0, leave it unchanged.
- R9: With `clr_mode` = 1 (clear on read), a cycle with `rd_strobe` = 1 clears `delta`, and `wr_strobe` has no effect.
- R10: If an acceptance and a clear event fall in the same cycle, `delta` is 1 after that edge.
- R11: `irq` equals the value of `delta AND NOT delta_mask` from the previous cycle, so it lags `delta` by one clock and stays 0 while the mask is 1.
- R12: Cycles with `frame_vld` = 0 neither advance nor break the consecutive-frame run, whatever `frame_byte` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_vld | input | 1 | One-cycle strobe marking the byte of a received frame |
| frame_byte | input | 8 | Extracted overhead byte, sampled when `frame_vld` is 1 |
| persist_n | input | 4 | Required number of consecutive identical frames (0 acts as 1) |
| clr_mode | input | 1 | 0 = delta clears on write, 1 = delta clears on read |
| rd_strobe | input | 1 | Read access strobe for the delta flag |
| wr_strobe | input | 1 | Write access strobe for the delta flag |
| wr_bit | input | 1 | Write data for the delta flag (1 clears) |
| delta_mask | input | 1 | 1 keeps `delta` off the interrupt |
| cur_byte | output | 8 | Currently accepted value |
| prev_byte | output | 8 | Accepted value that was replaced last |
| delta | output | 1 | Sticky change flag |
| irq | output | 1 | Registered masked interrupt |

## Verification
The assertions check on every cycle that the interrupt follows the masked flag one clock later. They also check that the current value moves only after a strobed frame, and only to that frame's byte. On every move, the previous value must take the old current value and the flag must be raised. Whenever the flag falls, a valid clear event for the selected mode must have occurred in the cycle before. The bench scenarios are needed for the counting rules: acceptance exactly on the Nth frame, the run restarting on a differing byte, gaps without a strobe, zero treated as one, suppression of an unchanged value, and set winning over clear.

// File: rtl/ovh_mon_pkg.sv
package ovh_mon_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic {
        CLR_ON_WRITE = 1'b0,
        CLR_ON_READ  = 1'b1
    } clr_mode_e;

    // Per-cycle control of the sticky flag
    typedef struct packed {
        logic set;
        logic clr;
    } delta_ctl_t;

    // Clear event for the selected access mode
    function automatic logic clear_event(input clr_mode_e mode, input logic rd,
                                         input logic wr, input logic wbit);
        return (mode == CLR_ON_READ) ? rd : (wr & wbit);
    endfunction

endpackage

// File: rtl/ovh_persist_filter.sv
module ovh_persist_filter #(
    parameter int BYTE_W = ovh_mon_pkg::BYTE_W,
    parameter int CNT_W  = ovh_mon_pkg::CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_vld,
    input  logic [BYTE_W-1:0] frame_byte,
    input  logic [CNT_W-1:0]  persist_n,
    input  logic [BYTE_W-1:0] cur_byte,
    output logic              acc_hit,
    output logic [BYTE_W-1:0] acc_value
);
    localparam logic [CNT_W-1:0] RUN_MAX = '1;
    localparam logic [CNT_W-1:0] RUN_ONE = CNT_W'(1);

    typedef struct packed {
        logic              have;
        logic [BYTE_W-1:0] value;
        logic [CNT_W-1:0]  run;
    } cand_t;

    cand_t            cand_q;
    logic             match;
    logic [CNT_W-1:0] run_nxt;
    logic [CNT_W-1:0] limit;

    always_comb begin
        match   = cand_q.have && (frame_byte == cand_q.value);
        run_nxt = RUN_ONE;
        if (match) begin
            run_nxt = (cand_q.run == RUN_MAX) ? RUN_MAX : cand_q.run + RUN_ONE;
        end
        limit     = (persist_n == '0) ? RUN_ONE : persist_n;
        acc_hit   = frame_vld && (run_nxt >= limit) && (frame_byte != cur_byte);
        acc_value = frame_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cand_q <= '0;
        end else if (frame_vld) begin
            cand_q.have  <= 1'b1;
            cand_q.value <= frame_byte;
            cand_q.run   <= run_nxt;
        end
    end
endmodule

// File: rtl/ovh_value_store.sv
module ovh_value_store #(
    parameter int BYTE_W = ovh_mon_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_hit,
    input  logic [BYTE_W-1:0] acc_value,
    output logic [BYTE_W-1:0] cur_byte,
    output logic [BYTE_W-1:0] prev_byte
);
    typedef struct packed {
        logic [BYTE_W-1:0] cur;
        logic [BYTE_W-1:0] prev;
    } pair_t;

    pair_t pair_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pair_q <= '0;
        end else if (acc_hit) begin
            pair_q.prev <= pair_q.cur;
            pair_q.cur  <= acc_value;
        end
    end

    assign cur_byte  = pair_q.cur;
    assign prev_byte = pair_q.prev;
endmodule

// File: rtl/ovh_delta_irq.sv
module ovh_delta_irq
    import ovh_mon_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       set_evt,
    input  clr_mode_e  mode,
    input  logic       rd_strobe,
    input  logic       wr_strobe,
    input  logic       wr_bit,
    input  logic       mask,
    output logic       delta,
    output logic       irq
);
    delta_ctl_t ctl;
    logic       delta_q;
    logic       irq_q;

    always_comb begin
        ctl.set = set_evt;
        ctl.clr = clear_event(mode, rd_strobe, wr_strobe, wr_bit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            delta_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            // set has priority over a clear in the same cycle
            delta_q <= ctl.set | (delta_q & ~ctl.clr);
            irq_q   <= delta_q & ~mask;
        end
    end

    assign delta = delta_q;
    assign irq   = irq_q;
endmodule

// File: rtl/ovh_byte_monitor.sv
module ovh_byte_monitor
    import ovh_mon_pkg::*;
#(
    parameter int BYTE_W = ovh_mon_pkg::BYTE_W,
    parameter int CNT_W  = ovh_mon_pkg::CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_vld,
    input  logic [BYTE_W-1:0] frame_byte,
    input  logic [CNT_W-1:0]  persist_n,
    input  logic              clr_mode,
    input  logic              rd_strobe,
    input  logic              wr_strobe,
    input  logic              wr_bit,
    input  logic              delta_mask,
    output logic [BYTE_W-1:0] cur_byte,
    output logic [BYTE_W-1:0] prev_byte,
    output logic              delta,
    output logic              irq
);
    logic              acc_hit;
    logic [BYTE_W-1:0] acc_value;
    clr_mode_e         mode;

    assign mode = clr_mode_e'(clr_mode);

    ovh_persist_filter #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_filter (
        .clk        (clk),
        .rst        (rst),
        .frame_vld  (frame_vld),
        .frame_byte (frame_byte),
        .persist_n  (persist_n),
        .cur_byte   (cur_byte),
        .acc_hit    (acc_hit),
        .acc_value  (acc_value)
    );

    ovh_value_store #(.BYTE_W(BYTE_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .acc_hit   (acc_hit),
        .acc_value (acc_value),
        .cur_byte  (cur_byte),
        .prev_byte (prev_byte)
    );

    ovh_delta_irq u_flag (
        .clk       (clk),
        .rst       (rst),
        .set_evt   (acc_hit),
        .mode      (mode),
        .rd_strobe (rd_strobe),
        .wr_strobe (wr_strobe),
        .wr_bit    (wr_bit),
        .mask      (delta_mask),
        .delta     (delta),
        .irq       (irq)
    );
endmodule

// File: rtl/ovh_byte_monitor_chk.sv
module ovh_byte_monitor_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_vld,
    input logic [BYTE_W-1:0] frame_byte,
    input logic              clr_mode,
    input logic              rd_strobe,
    input logic              wr_strobe,
    input logic              wr_bit,
    input logic              delta_mask,
    input logic [BYTE_W-1:0] cur_byte,
    input logic [BYTE_W-1:0] prev_byte,
    input logic              delta,
    input logic              irq
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) armed_q <= 1'b0;
        else     armed_q <= 1'b1;
    end

    p_irq_follow_r11: assert property (@(posedge clk) disable iff (rst || !armed_q)
        irq == $past(delta && !delta_mask));

    p_cur_needs_frame_r12: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (cur_byte != $past(cur_byte)) |-> $past(frame_vld));

    p_cur_from_byte_r2: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (cur_byte != $past(cur_byte)) |-> (cur_byte == $past(frame_byte)));

    p_prev_shift_r4: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (cur_byte != $past(cur_byte)) |-> (prev_byte == $past(cur_byte)));

    p_delta_on_change_r7: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (cur_byte != $past(cur_byte)) |-> delta);

    p_write_clear_r8: assert property (@(posedge clk) disable iff (rst || !armed_q)
        ($fell(delta) && !$past(clr_mode)) |-> $past(wr_strobe && wr_bit));

    p_read_clear_r9: assert property (@(posedge clk) disable iff (rst || !armed_q)
        ($fell(delta) && $past(clr_mode)) |-> $past(rd_strobe));
endmodule

bind ovh_byte_monitor ovh_byte_monitor_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_vld  (frame_vld),
    .frame_byte (frame_byte),
    .clr_mode   (clr_mode),
    .rd_strobe  (rd_strobe),
    .wr_strobe  (wr_strobe),
    .wr_bit     (wr_bit),
    .delta_mask (delta_mask),
    .cur_byte   (cur_byte),
    .prev_byte  (prev_byte),
    .delta      (delta),
    .irq        (irq)
);

// File: tb/ovh_byte_monitor_test.sv
module ovh_byte_monitor_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_vld = 1'b0;
    logic [7:0] frame_byte = 8'h00;
    logic [3:0] persist_n = 4'd3;
    logic       clr_mode = 1'b0;
    logic       rd_strobe = 1'b0;
    logic       wr_strobe = 1'b0;
    logic       wr_bit = 1'b0;
    logic       delta_mask = 1'b0;
    logic [7:0] cur_byte, prev_byte;
    logic       delta, irq;

    ovh_byte_monitor uut (
        .clk(clk), .rst(rst), .frame_vld(frame_vld), .frame_byte(frame_byte),
        .persist_n(persist_n), .clr_mode(clr_mode), .rd_strobe(rd_strobe),
        .wr_strobe(wr_strobe), .wr_bit(wr_bit), .delta_mask(delta_mask),
        .cur_byte(cur_byte), .prev_byte(prev_byte), .delta(delta), .irq(irq)
    );

    always #10 clk = ~clk;   // 50 MHz

    typedef struct {
        int         due;
        logic [7:0] cur;
        logic [7:0] prev;
        logic       dlt;
        logic       irq;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    // reference state built from the requirements
    logic [7:0] m_cur = 8'h00, m_prev = 8'h00, m_cand = 8'h00;
    logic       m_have = 1'b0, m_delta = 1'b0;
    int         m_run = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pop items that are due and compare
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due == cyc) begin
            exp_t e;
            e = q.pop_front();
            n_run++;
            if (cur_byte !== e.cur || prev_byte !== e.prev || delta !== e.dlt || irq !== e.irq) begin
                n_fail++;
                $display("FAIL %s: cur/prev/delta/irq actual %h/%h/%b/%b expected %h/%h/%b/%b",
                         e.tag, cur_byte, prev_byte, delta, irq, e.cur, e.prev, e.dlt, e.irq);
            end
        end
    end

    // driver: one cycle of stimulus, expected result pushed for the next edge
    task automatic step(input bit fv, input logic [7:0] b, input bit rd, input bit wr,
                        input bit wb, input string tag);
        exp_t e;
        int   lim;
        bit   acc, clr;
        frame_vld  = fv;
        frame_byte = b;
        rd_strobe  = rd;
        wr_strobe  = wr;
        wr_bit     = wb;
        lim = (persist_n == 0) ? 1 : int'(persist_n);
        acc = 1'b0;
        if (fv) begin
            if (m_have && b == m_cand) m_run = (m_run < 15) ? m_run + 1 : 15;
            else begin
                m_cand = b;
                m_run  = 1;
                m_have = 1'b1;
            end
            acc = (m_run >= lim) && (b != m_cur);
        end
        clr = clr_mode ? rd : (wr && wb);
        e.irq = m_delta && !delta_mask;
        if (acc) begin
            m_prev = m_cur;
            m_cur  = b;
        end
        m_delta = acc || (m_delta && !clr);
        e.due  = cyc + 1;
        e.cur  = m_cur;
        e.prev = m_prev;
        e.dlt  = m_delta;
        e.tag  = tag;
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, tag);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: values during reset
        n_run++;
        if (cur_byte !== 8'h00 || prev_byte !== 8'h00 || delta !== 1'b0 || irq !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 in reset: actual %h/%h/%b/%b expected 00/00/0/0", cur_byte, prev_byte, delta, irq);
        end
        rst = 1'b0;
        idle(1, "R1");

        // R2: acceptance exactly on the third frame
        for (int i = 0; i < 3; i++) step(1'b1, 8'hA5, 1'b0, 1'b0, 1'b0, "R2");
        idle(2, "R11");

        // R8: clear-on-write mode
        step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R8");
        step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, "R8");
        step(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, "R8");
        idle(2, "R11");

        // R3: differing byte restarts the run
        step(1'b1, 8'h3C, 1'b0, 1'b0, 1'b0, "R3");
        step(1'b1, 8'h3C, 1'b0, 1'b0, 1'b0, "R3");
        step(1'b1, 8'h5A, 1'b0, 1'b0, 1'b0, "R3");
        for (int i = 0; i < 3; i++) step(1'b1, 8'h3C, 1'b0, 1'b0, 1'b0, "R3");
        idle(1, "R4");
        step(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, "R8");

        // R5: value equal to current never sets delta
        for (int i = 0; i < 5; i++) step(1'b1, 8'h3C, 1'b0, 1'b0, 1'b0, "R5");
        idle(2, "R5");

        // R12: cycles without strobe do not break the run
        step(1'b1, 8'h77, 1'b0, 1'b0, 1'b0, "R12");
        step(1'b0, 8'h11, 1'b0, 1'b0, 1'b0, "R12");
        step(1'b0, 8'h11, 1'b0, 1'b0, 1'b0, "R12");
        step(1'b1, 8'h77, 1'b0, 1'b0, 1'b0, "R12");
        step(1'b1, 8'h77, 1'b0, 1'b0, 1'b0, "R12");
        idle(1, "R4");
        step(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, "R8");

        // R6: zero count acts as one
        persist_n = 4'd0;
        step(1'b1, 8'h99, 1'b0, 1'b0, 1'b0, "R6");
        idle(1, "R6");
        step(1'b1, 8'h42, 1'b0, 1'b0, 1'b0, "R6");
        idle(1, "R4");
        persist_n = 4'd3;

        // R9: clear-on-read mode
        clr_mode = 1'b1;
        step(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, "R9");
        step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R9");
        idle(1, "R9");

        // R10: accept and clear in the same cycle
        step(1'b1, 8'hE1, 1'b0, 1'b0, 1'b0, "R10");
        step(1'b1, 8'hE1, 1'b0, 1'b0, 1'b0, "R10");
        step(1'b1, 8'hE1, 1'b1, 1'b0, 1'b0, "R10");
        idle(2, "R10");

        // R11: mask holds interrupt low, unmask lets it through
        step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R9");
        delta_mask = 1'b1;
        for (int i = 0; i < 3; i++) step(1'b1, 8'hD2, 1'b0, 1'b0, 1'b0, "R11");
        idle(2, "R11");
        delta_mask = 1'b0;
        idle(2, "R11");

        idle(2, "R7");
        summary();
    end
endmodule